// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Sequencer

This block sits between a host register bus and the frame engine of a DMA-style Ethernet MAC. It holds a shared table of buffer descriptors. Each descriptor has a status/control word and a buffer address word. The table is split into a transmit ring, at the low indices, and a receive ring, which starts at a programmable boundary. Software fills a descriptor and hands it over by setting its ownership bit: READY for transmit, EMPTY for receive. Two independent walkers then step through the rings. Each one presents the owned descriptor to the frame engine. When the engine reports completion, the walker writes the outcome back into the descriptor and advances.

The transmit walker has three states. TX_OFF holds the pointer at index 0. TX_POLL re-reads the current descriptor every cycle until READY is set. TX_HAND presents the descriptor and waits for `tx_done`. The transitions are OFF→POLL when transmit is enabled, POLL→HAND when READY is seen, HAND→POLL on completion, and any state→OFF when transmit is disabled. The receive walker mirrors this with RX_OFF (pointer parked at the boundary), RX_POLL (waits for EMPTY) and RX_ARMED (accepts the next frame). Completions raise bits in an interrupt source register. These bits are cleared by writing 1, and a mask selects which of them reach the interrupt line.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, `irq`, `tx_valid` and `rx_ready` are 0, the mode (0x00), source (0x04) and mask (0x08) registers read 0, and the transmit count register (0x20) reads 64.
- R2: A write to 0x20 stores the transmit descriptor count N. A value above 128 is stored as 128.
- R3: Descriptor i is at byte 0x400+8*i: the status word first, then the buffer address. Once transmit descriptor i has READY (bit 15) set, `tx_valid` rises with `tx_idx`=i, `tx_buf_addr` = its address word and `tx_len` = status bits 31:16. These stay held until `tx_done`.
- R4: While the current transmit descriptor has READY clear, `tx_valid` stays 0. The descriptor is re-examined every cycle, so setting READY later starts the hand-off.
- R5: On `tx_done`, the descriptor status has READY cleared and bits 8:0 replaced by `tx_err`. All other bits are kept.
- R6: A descriptor whose WRAP bit (13) is set is the last of its ring. After it, the pointer returns to index 0 for transmit, or to index N for receive. Otherwise it moves to the next index.
- R7: A completion raises a source bit only if the descriptor's IRQ bit (14) is set. For transmit, bit 0 is raised if `tx_err` is zero and bit 1 if it is nonzero.
- R8: Writing 1 to a source bit clears it. `irq` is the OR of the source bits ANDed with the mask.
- R9: The receive ring starts at index N. When the current receive descriptor has EMPTY (bit 15) set, `rx_ready` is 1. On `rx_done`, the status takes `rx_len` in bits 31:16, EMPTY is cleared and bits 8:0 take `rx_stat`.
- R10: For a receive completion with IRQ set, source bit 2 is raised if `rx_stat[7:0]` is zero and bit 3 if it is nonzero, and bit 6 is raised if `rx_stat[8]` (control frame) is set. An `rx_done` while receive is enabled but no EMPTY descriptor is held raises bit 4, and it leaves the descriptors unchanged.
- R11: Clearing mode bit 1 (transmit enable) returns the transmit pointer to index 0. Clearing mode bit 0 (receive enable) returns the receive pointer to index N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Masked interrupt request |
| tx_valid | output | 1 | Transmit descriptor presented |
| tx_idx | output | 7 | Index of the presented transmit descriptor |
| tx_buf_addr | output | 32 | Its buffer address |
| tx_len | output | 16 | Its frame length |
| tx_done | input | 1 | Engine finished the presented frame |
| tx_err | input | 9 | Transmit error fields for write-back |
| rx_ready | output | 1 | Empty receive descriptor held |
| rx_idx | output | 7 | Index of the held receive descriptor |
| rx_buf_addr | output | 32 | Its buffer address |
| rx_done | input | 1 | Engine finished receiving a frame |
| rx_len | input | 16 | Received length including FCS |
| rx_stat | input | 9 | Receive status flags for write-back |

## Verification
A pointer that drifts shows up at the next hand-off. `tx_idx` or `rx_idx` would name the wrong descriptor, or the write-back would land in the wrong status word, and a later bus read of that descriptor makes either visible. A walker stuck in the wrong state shows up within a few cycles. Either `tx_valid`/`rx_ready` fails to rise after ownership is granted, or it stays high after the ring is disabled. A mis-routed event shows up on the source register and on `irq` in the cycle after the completion.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_POLL,
        TX_HAND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_POLL,
        RX_ARMED
    } rx_state_t;

    // status word bit positions shared by both rings
    localparam int B_OWN  = 15;
    localparam int B_IRQ  = 14;
    localparam int B_WRAP = 13;

    // interrupt source bit positions
    localparam int SRC_W    = 7;
    localparam int SRC_TXF  = 0;
    localparam int SRC_TXE  = 1;
    localparam int SRC_RXF  = 2;
    localparam int SRC_RXE  = 3;
    localparam int SRC_BUSY = 4;
    localparam int SRC_TXC  = 5;
    localparam int SRC_RXC  = 6;

    // register offsets
    localparam int OFS_MODE = 'h00;
    localparam int OFS_SRC  = 'h04;
    localparam int OFS_MASK = 'h08;
    localparam int OFS_NTX  = 'h20;
    localparam int OFS_DESC = 'h400;

endpackage

// File: rtl/bd_ring_regs.sv
module bd_ring_regs
    import bd_ring_pkg::*;
#(
    parameter int DESCS = 128,
    localparam int IDX_W = $clog2(DESCS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel_mode,
    input  logic              sel_src,
    input  logic              sel_mask,
    input  logic              sel_ntx,
    input  logic [31:0]       wdata,
    input  logic [SRC_W-1:0]  events,
    output logic              tx_en,
    output logic              rx_en,
    output logic [SRC_W-1:0]  src,
    output logic [SRC_W-1:0]  mask,
    output logic [IDX_W:0]    ntx,
    output logic              irq
);
    localparam logic [IDX_W:0] NTX_RESET = (IDX_W+1)'(DESCS / 2);
    localparam logic [IDX_W:0] NTX_MAX   = (IDX_W+1)'(DESCS);

    logic [SRC_W-1:0] clr;

    assign clr = (we && sel_src) ? wdata[SRC_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
            src   <= '0;
            mask  <= '0;
            ntx   <= NTX_RESET;
        end else begin
            if (we && sel_mode) begin
                rx_en <= wdata[0];
                tx_en <= wdata[1];
            end
            if (we && sel_mask)
                mask <= wdata[SRC_W-1:0];
            if (we && sel_ntx)
                ntx <= (wdata > 32'(DESCS)) ? NTX_MAX : wdata[IDX_W:0];
            // a new event in the same cycle wins over a clear
            src <= (src & ~clr) | events;
        end
    end

    assign irq = |(src & mask);

endmodule

// File: rtl/bd_ring_mem.sv
module bd_ring_mem #(
    parameter int DESCS = 128,
    localparam int IDX_W = $clog2(DESCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    // host port
    input  logic             host_we,
    input  logic             host_word,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    // transmit walker port
    input  logic [IDX_W-1:0] tx_idx,
    input  logic             tx_wb,
    input  logic [8:0]       tx_wb_err,
    output logic [15:0]      tx_len,
    output logic [2:0]       tx_flags,
    output logic [31:0]      tx_addr,
    // receive walker port
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             rx_wb,
    input  logic [15:0]      rx_wb_len,
    input  logic [8:0]       rx_wb_stat,
    output logic [2:0]       rx_flags,
    output logic [31:0]      rx_addr
);
    logic [31:0] stat_q [DESCS];
    logic [31:0] addr_q [DESCS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DESCS; i++) begin
                stat_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DESCS; i++) begin
                if (tx_wb && tx_idx == IDX_W'(i))
                    stat_q[i] <= {stat_q[i][31:16], 1'b0, stat_q[i][14:9], tx_wb_err};
                else if (rx_wb && rx_idx == IDX_W'(i))
                    stat_q[i] <= {rx_wb_len, 1'b0, stat_q[i][14:9], rx_wb_stat};
                else if (host_we && !host_word && host_idx == IDX_W'(i))
                    stat_q[i] <= host_wdata;
                if (host_we && host_word && host_idx == IDX_W'(i))
                    addr_q[i] <= host_wdata;
            end
        end
    end

    assign host_rdata = host_word ? addr_q[host_idx] : stat_q[host_idx];
    assign tx_len     = stat_q[tx_idx][31:16];
    assign tx_flags   = stat_q[tx_idx][15:13];
    assign tx_addr    = addr_q[tx_idx];
    assign rx_flags   = stat_q[rx_idx][15:13];
    assign rx_addr    = addr_q[rx_idx];

endmodule

// File: rtl/bd_ring_tx_walk.sv
module bd_ring_tx_walk
    import bd_ring_pkg::*;
#(
    parameter int DESCS = 128,
    localparam int IDX_W = $clog2(DESCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W:0]   ntx,
    input  logic             cur_own,
    input  logic             cur_irq,
    input  logic             cur_wrap,
    input  logic             done,
    input  logic [8:0]       err,
    output logic [IDX_W-1:0] ptr,
    output logic             hand,
    output logic             wb,
    output logic             ev_frame,
    output logic             ev_err
);
    tx_state_t        state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             last;

    assign last = cur_wrap || ({1'b0, ptr_q} == ntx - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            TX_OFF: begin
                ptr_d = '0;
                if (en) state_d = TX_POLL;
            end
            TX_POLL: begin
                if (!en) begin
                    state_d = TX_OFF;
                    ptr_d   = '0;
                end else if (ntx != '0 && cur_own) begin
                    state_d = TX_HAND;
                end
            end
            TX_HAND: begin
                if (!en) begin
                    state_d = TX_OFF;
                    ptr_d   = '0;
                end else if (done) begin
                    state_d = TX_POLL;
                    ptr_d   = last ? '0 : ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = TX_OFF;
                ptr_d   = '0;
            end
        endcase
    end

    always_comb begin
        hand     = (state_q == TX_HAND);
        wb       = hand && en && done;
        ev_frame = wb && cur_irq && (err == '0);
        ev_err   = wb && cur_irq && (err != '0);
        ptr      = ptr_q;
    end

endmodule

// File: rtl/bd_ring_rx_walk.sv
module bd_ring_rx_walk
    import bd_ring_pkg::*;
#(
    parameter int DESCS = 128,
    localparam int IDX_W = $clog2(DESCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W:0]   base,
    input  logic             cur_own,
    input  logic             cur_irq,
    input  logic             cur_wrap,
    input  logic             frame,
    input  logic [8:0]       stat,
    output logic [IDX_W-1:0] ptr,
    output logic             armed,
    output logic             wb,
    output logic             ev_frame,
    output logic             ev_err,
    output logic             ev_ctl,
    output logic             ev_busy
);
    localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(DESCS - 1);

    rx_state_t      state_q, state_d;
    logic [IDX_W:0] ptr_q, ptr_d;
    logic           in_ring;
    logic           last;

    assign in_ring = (ptr_q <= LAST_IDX);
    assign last    = cur_wrap || (ptr_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            RX_OFF: begin
                ptr_d = base;
                if (en) state_d = RX_POLL;
            end
            RX_POLL: begin
                if (!en) begin
                    state_d = RX_OFF;
                    ptr_d   = base;
                end else if (in_ring && cur_own) begin
                    state_d = RX_ARMED;
                end
            end
            RX_ARMED: begin
                if (!en) begin
                    state_d = RX_OFF;
                    ptr_d   = base;
                end else if (frame) begin
                    state_d = RX_POLL;
                    ptr_d   = last ? base : ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = RX_OFF;
                ptr_d   = base;
            end
        endcase
    end

    always_comb begin
        armed    = (state_q == RX_ARMED);
        wb       = armed && en && frame;
        ev_frame = wb && cur_irq && (stat[7:0] == '0);
        ev_err   = wb && cur_irq && (stat[7:0] != '0);
        ev_ctl   = wb && cur_irq && stat[8];
        ev_busy  = frame && en && !armed;
        ptr      = ptr_q[IDX_W-1:0];
    end

endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
    import bd_ring_pkg::*;
#(
    parameter int DESCS  = 128,
    parameter int ADDR_W = 11,
    localparam int IDX_W = $clog2(DESCS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [31:0]       tx_buf_addr,
    output logic [15:0]       tx_len,
    input  logic              tx_done,
    input  logic [8:0]        tx_err,
    output logic              rx_ready,
    output logic [IDX_W-1:0]  rx_idx,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_stat
);
    localparam int DESC_END = OFS_DESC + DESCS * 8;

    logic [31:0]      addr32;
    logic             desc_hit, sel_mode, sel_src, sel_mask, sel_ntx;
    logic [IDX_W-1:0] host_idx;
    logic [31:0]      host_rdata;
    logic             tx_en, rx_en, tx_wb, rx_wb;
    logic [SRC_W-1:0] int_src, int_mask, events;
    logic [IDX_W:0]   ntx;
    logic [2:0]       tx_flags, rx_flags;
    logic             tx_ev_f, tx_ev_e;
    logic             rx_ev_f, rx_ev_e, rx_ev_c, rx_ev_b;

    assign addr32   = 32'(bus_addr);
    assign desc_hit = (addr32 >= 32'(OFS_DESC)) && (addr32 < 32'(DESC_END));
    assign host_idx = IDX_W'((addr32 - 32'(OFS_DESC)) >> 3);
    assign sel_mode = (addr32 == 32'(OFS_MODE));
    assign sel_src  = (addr32 == 32'(OFS_SRC));
    assign sel_mask = (addr32 == 32'(OFS_MASK));
    assign sel_ntx  = (addr32 == 32'(OFS_NTX));

    always_comb begin
        events           = '0;
        events[SRC_TXF]  = tx_ev_f;
        events[SRC_TXE]  = tx_ev_e;
        events[SRC_RXF]  = rx_ev_f;
        events[SRC_RXE]  = rx_ev_e;
        events[SRC_BUSY] = rx_ev_b;
        events[SRC_TXC]  = 1'b0;
        events[SRC_RXC]  = rx_ev_c;
    end

    bd_ring_regs #(.DESCS(DESCS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .sel_mode (sel_mode),
        .sel_src  (sel_src),
        .sel_mask (sel_mask),
        .sel_ntx  (sel_ntx),
        .wdata    (bus_wdata),
        .events   (events),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .src      (int_src),
        .mask     (int_mask),
        .ntx      (ntx),
        .irq      (irq)
    );

    bd_ring_mem #(.DESCS(DESCS)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (bus_we && desc_hit),
        .host_word  (addr32[2]),
        .host_idx   (host_idx),
        .host_wdata (bus_wdata),
        .host_rdata (host_rdata),
        .tx_idx     (tx_idx),
        .tx_wb      (tx_wb),
        .tx_wb_err  (tx_err),
        .tx_len     (tx_len),
        .tx_flags   (tx_flags),
        .tx_addr    (tx_buf_addr),
        .rx_idx     (rx_idx),
        .rx_wb      (rx_wb),
        .rx_wb_len  (rx_len),
        .rx_wb_stat (rx_stat),
        .rx_flags   (rx_flags),
        .rx_addr    (rx_buf_addr)
    );

    bd_ring_tx_walk #(.DESCS(DESCS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .ntx      (ntx),
        .cur_own  (tx_flags[2]),
        .cur_irq  (tx_flags[1]),
        .cur_wrap (tx_flags[0]),
        .done     (tx_done),
        .err      (tx_err),
        .ptr      (tx_idx),
        .hand     (tx_valid),
        .wb       (tx_wb),
        .ev_frame (tx_ev_f),
        .ev_err   (tx_ev_e)
    );

    bd_ring_rx_walk #(.DESCS(DESCS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .base     (ntx),
        .cur_own  (rx_flags[2]),
        .cur_irq  (rx_flags[1]),
        .cur_wrap (rx_flags[0]),
        .frame    (rx_done),
        .stat     (rx_stat),
        .ptr      (rx_idx),
        .armed    (rx_ready),
        .wb       (rx_wb),
        .ev_frame (rx_ev_f),
        .ev_err   (rx_ev_e),
        .ev_ctl   (rx_ev_c),
        .ev_busy  (rx_ev_b)
    );

    always_comb begin
        bus_rdata = '0;
        if (desc_hit)      bus_rdata = host_rdata;
        else if (sel_mode) bus_rdata = {30'b0, tx_en, rx_en};
        else if (sel_src)  bus_rdata = 32'(int_src);
        else if (sel_mask) bus_rdata = 32'(int_mask);
        else if (sel_ntx)  bus_rdata = 32'(ntx);
    end

endmodule

// File: rtl/bd_ring_seq_chk.sv
module bd_ring_seq_chk #(
    parameter int DESCS = 128,
    localparam int IDX_W = $clog2(DESCS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             tx_en,
    input logic             rx_en,
    input logic             tx_valid,
    input logic             tx_done,
    input logic [IDX_W-1:0] tx_idx,
    input logic             rx_ready,
    input logic             rx_done,
    input logic [IDX_W-1:0] rx_idx,
    input logic [IDX_W:0]   ntx,
    input logic [6:0]       int_src,
    input logic [6:0]       int_mask,
    input logic             irq
);
    AST_TX_INSIDE_RING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ({1'b0, tx_idx} < ntx)); // R6

    AST_RX_INSIDE_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !bus_we) |-> ({1'b0, rx_idx} >= ntx)); // R9

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !bus_we) |=> (tx_valid && $stable(tx_idx))); // R3

    AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_valid); // R11

    AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready); // R11

    AST_BUSY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && !rx_ready) |=> int_src[4]); // R10

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == '0) |-> !irq); // R8

endmodule

bind bd_ring_seq bd_ring_seq_chk #(.DESCS(DESCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_valid (tx_valid),
    .tx_done  (tx_done),
    .tx_idx   (tx_idx),
    .rx_ready (rx_ready),
    .rx_done  (rx_done),
    .rx_idx   (rx_idx),
    .ntx      (ntx),
    .int_src  (int_src),
    .int_mask (int_mask),
    .irq      (irq)
);

// File: tb/bd_ring_seq_test.sv
module bd_ring_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, rx_ready;
    logic [6:0]  tx_idx, rx_idx;
    logic [31:0] tx_buf_addr, rx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_err = '0;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_stat = '0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bd_ring_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_buf_addr(tx_buf_addr),
        .tx_len(tx_len), .tx_done(tx_done), .tx_err(tx_err),
        .rx_ready(rx_ready), .rx_idx(rx_idx), .rx_buf_addr(rx_buf_addr),
        .rx_done(rx_done), .rx_len(rx_len), .rx_stat(rx_stat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 11'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_tx(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = tx_valid;
        end
    endtask

    task automatic wait_rx(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = rx_ready;
        end
    endtask

    task automatic tx_finish(input logic [8:0] e);
        @(negedge clk);
        tx_done = 1'b1; tx_err = e;
        @(negedge clk);
        tx_done = 1'b0; tx_err = '0;
    endtask

    task automatic rx_frame(input logic [15:0] l, input logic [8:0] s);
        @(negedge clk);
        rx_done = 1'b1; rx_len = l; rx_stat = s;
        @(negedge clk);
        rx_done = 1'b0; rx_len = '0; rx_stat = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 rx_ready", 32'(rx_ready), 0);
        rd('h00, v); check("R1 mode", v, 0);
        rd('h04, v); check("R1 src", v, 0);
        rd('h08, v); check("R1 mask", v, 0);
        rd('h20, v); check("R1 ntx", v, 64);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr('h20, 200); rd('h20, v); check("R2 saturate", v, 128);
        wr('h20, 4);   rd('h20, v); check("R2 plain", v, 4);
    endtask

    task automatic t_tx_basic();
        logic [31:0] v;
        logic seen;
        wr('h404, 32'h0000_2000);
        wr('h400, 32'h0064_4800);
        wr('h00, 32'h2);
        repeat (6) @(negedge clk);
        check("R4 stalled", 32'(tx_valid), 0);
        wr('h400, 32'h0064_C800);
        wait_tx(seen);
        check("R4 resumes", 32'(seen), 1);
        check("R3 idx", 32'(tx_idx), 0);
        check("R3 addr", tx_buf_addr, 32'h2000);
        check("R3 len", 32'(tx_len), 100);
        tx_finish(9'h000);
        rd('h400, v); check("R5 writeback", v, 32'h0064_4800);
        rd('h04, v);  check("R7 tx done bit", v, 32'h01);
        check("R8 masked off", 32'(irq), 0);
        wr('h08, 32'h01);
        @(negedge clk); check("R8 irq on", 32'(irq), 1);
        wr('h04, 32'h01);
        rd('h04, v); check("R8 w1c", v, 0);
        check("R8 irq off", 32'(irq), 0);
    endtask

    task automatic t_tx_wrap();
        logic [31:0] v;
        logic seen;
        wr('h40C, 32'h0000_3000);
        wr('h408, 32'h003C_A000);
        wait_tx(seen);
        check("R3 second idx", 32'(tx_idx), 1);
        tx_finish(9'h008);
        rd('h408, v); check("R5 error kept", v, 32'h003C_2008);
        rd('h04, v);  check("R7 no irq bit", v, 0);
        wr('h400, 32'h0050_C000);
        wait_tx(seen);
        check("R6 tx wrap to 0", 32'(tx_idx), 0);
        tx_finish(9'h104);
        rd('h400, v); check("R5 error status", v, 32'h0050_4104);
        rd('h04, v);  check("R7 tx error bit", v, 32'h02);
        wr('h04, 32'h7F);
    endtask

    task automatic t_tx_disable();
        logic seen;
        wr('h00, 32'h0);
        wr('h00, 32'h2);
        wr('h400, 32'h0040_8000);
        wait_tx(seen);
        check("R11 tx restart idx", 32'(tx_idx), 0);
        tx_finish(9'h000);
        wr('h00, 32'h0);
        @(negedge clk);
        check("R11 tx idle", 32'(tx_valid), 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        logic seen;
        wr('h424, 32'h0000_1000);
        wr('h420, 32'h0000_C000);
        wr('h42C, 32'h0000_1800);
        wr('h428, 32'h0000_E000);
        wr('h00, 32'h1);
        wait_rx(seen);
        check("R9 armed", 32'(seen), 1);
        check("R9 first idx", 32'(rx_idx), 4);
        check("R9 buf addr", rx_buf_addr, 32'h1000);
        rx_frame(16'd64, 9'h000);
        rd('h420, v); check("R9 writeback", v, 32'h0040_4000);
        rd('h04, v);  check("R10 rx done", v, 32'h04);
        wait_rx(seen);
        check("R9 next idx", 32'(rx_idx), 5);
        rx_frame(16'h0080, 9'h108);
        rd('h428, v); check("R9 err writeback", v, 32'h0080_6108);
        rd('h04, v);  check("R10 err+ctl", v, 32'h4C);
        repeat (3) @(negedge clk);
        check("R6 rx wrapped to owned", 32'(rx_ready), 0);
        wr('h04, 32'h7F);
        rx_frame(16'd80, 9'h000);
        rd('h04, v);  check("R10 busy", v, 32'h10);
        rd('h420, v); check("R10 desc untouched", v, 32'h0040_4000);
        wr('h420, 32'h0000_C000);
        wait_rx(seen);
        check("R6 rx wrap to base", 32'(rx_idx), 4);
        wr('h00, 32'h0);
        @(negedge clk);
        check("R11 rx idle", 32'(rx_ready), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_tx_basic();
        t_tx_wrap();
        t_tx_disable();
        t_rx();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule